// File: doc/BRIEF.md
# Interrupt Control Register Bank

This block holds the per-line control state of an interrupt controller serving 32·K request lines and exposes it through a word-addressed register bus with byte-lane strobes. Every line owns an enable bit, a pending bit, a read-only active bit supplied from outside, and a priority field. Enable and pending state are each reached through two register groups. One group only sets bits when a 1 is written. The other only clears bits when a 1 is written. Both groups read back the same live state.

Pending bits are also set in hardware when a line's request input rises. From the registered state the bank continuously reports the most urgent line that is both pending and enabled. A smaller priority number means more urgent, and equal priorities go to the lower line number. The core that owns exception sequencing reads that result and drives the active vector back in.

The bus is word addressed (`bus_addr` counts 32-bit words; a byte offset is four times the word address). Word bases of the groups: 0x00 set-enable, 0x20 clear-enable, 0x40 set-pending, 0x60 clear-pending, 0x80 active, 0xC0 priority. Word addresses 0xA0–0xBF are unmapped. The design has no sequencing state. Its only registers are the state bits, the priority fields, the request-edge history and the read response register.

Top module: `irq_reg_bank`

## Requirements
- R1: In each bitmap group, line n is bit n%32 of the word at group base + n/32, so the word index within the group is `bus_addr[4:0]`. On a write, data bits in a byte lane whose `bus_be` bit is 0 are ignored.
- R2: Writing 1 to a bit of set-enable enables that line. Writing 1 to a bit of clear-enable disables it. Bits written as 0 leave the line unchanged.
- R3: Reads of either enable group return the current enable bits. Reads of either pending group return the current pending bits.
- R4: Writing 1 to a bit of set-pending makes that line pending. Writing 1 to a bit of clear-pending removes it. Bits written as 0 leave the line unchanged.
- R5: The active group reads the `irq_active` input. Writes to it change nothing.
- R6: In a bitmap group, a word index at or above K reads zero and ignores writes. So do unmapped addresses and priority words at or above 0xC0 + 8·K.
- R7: Line n's priority sits in priority word n/4, bits (n%4)*8+7 down to (n%4)*8. Only the top PRIO_BITS bits of each byte are stored, and the lower bits read as zero.
- R8: With BYTE_WRITES=1, a priority write updates only the fields whose byte lane is strobed. With BYTE_WRITES=0, a priority write counts only when all four strobes are set and is otherwise ignored.
- R9: A rising edge on `irq_req[n]` sets pending bit n on that clock. A request held high does not set the bit again once it has been cleared. An edge wins over a clear-pending write to the same line in the same cycle.
- R10: `win_valid` is 1 exactly when some line is both pending and enabled. `win_id` then names the one with the lowest stored priority, and among equal priorities the lowest line number. Both follow the state as it is after each clock edge.
- R11: A read strobed on one clock returns its data in `bus_rdata`, with `bus_rvalid` high, during the next cycle. If a write is issued in the same cycle, the read returns the state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Word address |
| bus_be | input | 4 | Byte-lane strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |
| irq_req | input | 32·K | Request lines, rising edge sets pending |
| irq_active | input | 32·K | Active bits from the exception logic |
| win_valid | output | 1 | A pending and enabled line exists |
| win_id | output | log2(32·K) | Most urgent pending and enabled line |

## Verification
The bench targets the priority ties. A strict/non-strict compare swap would hand the win to the higher line number. It also targets the request edge that meets a same-cycle clear-pending: a design that gives the clear priority would lose the interrupt. A request held high across a clear is checked too, because level detection would make the line pend again. Partial byte-lane writes to both bitmap and priority words are checked, since ignoring strobes would corrupt neighbouring lines. Finally, a second instance built with word-only priority access must drop a single-lane write, and the main bank must read zero from reserved words and unmapped space even after writes to them.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int FIELD_W = 8;

    typedef enum logic [2:0] {
        GRP_SET_EN,
        GRP_CLR_EN,
        GRP_SET_PEND,
        GRP_CLR_PEND,
        GRP_ACTIVE,
        GRP_PRIO,
        GRP_NONE
    } grp_e;

    // Group is chosen by the top three word-address bits.
    function automatic grp_e decode_grp(input logic [ADDR_W-1:0] a);
        unique case (a[ADDR_W-1:ADDR_W-3])
            3'd0:       return GRP_SET_EN;
            3'd1:       return GRP_CLR_EN;
            3'd2:       return GRP_SET_PEND;
            3'd3:       return GRP_CLR_PEND;
            3'd4:       return GRP_ACTIVE;
            3'd6, 3'd7: return GRP_PRIO;
            default:    return GRP_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*8 +: 8] = {8{be[i]}};
        return m;
    endfunction

endpackage

// File: rtl/irq_bitmap_regs.sv
module irq_bitmap_regs #(
    parameter int K = 1,
    localparam int N = 32 * K
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [4:0]   word_idx,
    input  logic [31:0]  wmask,
    input  logic [N-1:0] req,
    output logic [N-1:0] state
);

    logic [N-1:0] set_v;
    logic [N-1:0] clr_v;
    logic [N-1:0] req_q;
    logic [N-1:0] rise;

    generate
        for (genvar w = 0; w < K; w++) begin : g_word
            assign set_v[w*32 +: 32] = (set_we && word_idx == 5'(w)) ? wmask : '0;
            assign clr_v[w*32 +: 32] = (clr_we && word_idx == 5'(w)) ? wmask : '0;
        end
    endgenerate

    assign rise = req & ~req_q;

    // Request edge is ORed last so it beats a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
            req_q <= '0;
        end else begin
            req_q <= req;
            state <= ((state | set_v) & ~clr_v) | rise;
        end
    end

endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
    parameter int K           = 1,
    parameter int PRIO_BITS   = 3,
    parameter int BYTE_WRITES = 1,
    localparam int N     = 32 * K,
    localparam int WORDS = N / 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [5:0]             word_idx,
    input  logic [3:0]             be,
    input  logic [31:0]            wdata,
    output logic [N*PRIO_BITS-1:0] prio_flat,
    output logic [31:0]            rd_word
);

    logic unused_wdata_bits;
    assign unused_wdata_bits = ^wdata;

    generate
        for (genvar n = 0; n < N; n++) begin : g_line
            localparam int WI = n / 4;
            localparam int FI = n % 4;
            logic                 lane_ok;
            logic [PRIO_BITS-1:0] val_q;

            if (BYTE_WRITES != 0) begin : g_byte
                assign lane_ok = be[FI];
            end else begin : g_word
                assign lane_ok = &be;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (wr_en && word_idx == 6'(WI) && lane_ok) begin
                    val_q <= wdata[FI*8 + 8 - PRIO_BITS +: PRIO_BITS];
                end
            end

            assign prio_flat[n*PRIO_BITS +: PRIO_BITS] = val_q;
        end
    endgenerate

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (word_idx == 6'(w)) begin
                for (int f = 0; f < 4; f++) begin
                    rd_word[f*8 + 8 - PRIO_BITS +: PRIO_BITS] = prio_flat[(w*4+f)*PRIO_BITS +: PRIO_BITS];
                end
            end
        end
    end

endmodule

// File: rtl/irq_winner.sv
module irq_winner #(
    parameter int N         = 32,
    parameter int PRIO_BITS = 3,
    localparam int ID_W     = $clog2(N)
) (
    input  logic [N-1:0]           elig,
    input  logic [N*PRIO_BITS-1:0] prio_flat,
    output logic                   valid,
    output logic [ID_W-1:0]        id
);

    logic [PRIO_BITS-1:0] best;

    // Strict compare keeps the lowest index on equal priority.
    always_comb begin
        valid = 1'b0;
        id    = '0;
        best  = '1;
        for (int n = 0; n < N; n++) begin
            if (elig[n] && (!valid || prio_flat[n*PRIO_BITS +: PRIO_BITS] < best)) begin
                valid = 1'b1;
                best  = prio_flat[n*PRIO_BITS +: PRIO_BITS];
                id    = ID_W'(n);
            end
        end
    end

endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
    import irq_bank_pkg::*;
#(
    parameter int K           = 1,
    parameter int PRIO_BITS   = 3,
    parameter int BYTE_WRITES = 1,
    localparam int N    = 32 * K,
    localparam int ID_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [LANES-1:0]  bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [N-1:0]      irq_req,
    input  logic [N-1:0]      irq_active,
    output logic              win_valid,
    output logic [ID_W-1:0]   win_id
);

    grp_e                   grp;
    logic [DATA_W-1:0]      wmask;
    logic [N-1:0]           en_q;
    logic [N-1:0]           pend_q;
    logic [N*PRIO_BITS-1:0] prio_flat;
    logic [DATA_W-1:0]      prio_rd;
    logic [DATA_W-1:0]      en_rd;
    logic [DATA_W-1:0]      pend_rd;
    logic [DATA_W-1:0]      act_rd;
    logic [DATA_W-1:0]      rd_mux;

    assign grp   = decode_grp(bus_addr);
    assign wmask = bus_wdata & lane_mask(bus_be);

    irq_bitmap_regs #(.K(K)) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (bus_wr && grp == GRP_SET_EN),
        .clr_we   (bus_wr && grp == GRP_CLR_EN),
        .word_idx (bus_addr[4:0]),
        .wmask    (wmask),
        .req      ({N{1'b0}}),
        .state    (en_q)
    );

    irq_bitmap_regs #(.K(K)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (bus_wr && grp == GRP_SET_PEND),
        .clr_we   (bus_wr && grp == GRP_CLR_PEND),
        .word_idx (bus_addr[4:0]),
        .wmask    (wmask),
        .req      (irq_req),
        .state    (pend_q)
    );

    irq_prio_regs #(.K(K), .PRIO_BITS(PRIO_BITS), .BYTE_WRITES(BYTE_WRITES)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr && grp == GRP_PRIO),
        .word_idx  (bus_addr[5:0]),
        .be        (bus_be),
        .wdata     (bus_wdata),
        .prio_flat (prio_flat),
        .rd_word   (prio_rd)
    );

    irq_winner #(.N(N), .PRIO_BITS(PRIO_BITS)) u_win (
        .elig      (en_q & pend_q),
        .prio_flat (prio_flat),
        .valid     (win_valid),
        .id        (win_id)
    );

    always_comb begin
        en_rd   = '0;
        pend_rd = '0;
        act_rd  = '0;
        for (int w = 0; w < K; w++) begin
            if (bus_addr[4:0] == 5'(w)) begin
                en_rd   = en_q[w*32 +: 32];
                pend_rd = pend_q[w*32 +: 32];
                act_rd  = irq_active[w*32 +: 32];
            end
        end
    end

    always_comb begin
        unique case (grp)
            GRP_SET_EN, GRP_CLR_EN:     rd_mux = en_rd;
            GRP_SET_PEND, GRP_CLR_PEND: rd_mux = pend_rd;
            GRP_ACTIVE:                 rd_mux = act_rd;
            GRP_PRIO:                   rd_mux = prio_rd;
            default:                    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
    parameter int N = 32,
    localparam int ID_W = $clog2(N)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_rd,
    input logic            bus_wr,
    input logic [7:0]      bus_addr,
    input logic            be0,
    input logic            wd0,
    input logic            req0,
    input logic [N-1:0]    en_q,
    input logic [N-1:0]    pend_q,
    input logic            rvalid,
    input logic            win_valid,
    input logic [ID_W-1:0] win_id
);

    // R10
    win_is_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (en_q[win_id] && pend_q[win_id]));

    // R10
    no_win_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(en_q & pend_q)) |-> !win_valid);

    // R11
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rvalid);

    // R11
    no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !rvalid);

    // R2
    clear_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'h20 && be0 && wd0) |=> !en_q[0]);

    // R2
    zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == 8'h00 || bus_addr == 8'h20) && !(be0 && wd0)) |=> $stable(en_q[0]));

    // R9
    req_edge_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req0) |=> pend_q[0]);

endmodule

bind irq_reg_bank irq_bank_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .be0       (bus_be[0]),
    .wd0       (bus_wdata[0]),
    .req0      (irq_req[0]),
    .en_q      (en_q),
    .pend_q    (pend_q),
    .rvalid    (bus_rvalid),
    .win_valid (win_valid),
    .win_id    (win_id)
);

// File: tb/test_irq_reg_bank.sv
`timescale 1ns/1ps
module test_irq_reg_bank;

    localparam int K     = 2;
    localparam int N     = 32 * K;
    localparam int PB    = 3;
    localparam logic [7:0] PMASK = 8'hE0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, rdata_wo;
    logic        bus_rvalid, rvalid_wo;
    logic [N-1:0] irq_req = '0;
    logic [N-1:0] irq_active = '0;
    logic        win_valid, win_valid_wo;
    logic [5:0]  win_id;
    logic [4:0]  win_id_wo;

    int checks = 0;
    int fails  = 0;

    logic [N-1:0] en_m = '0;
    logic [N-1:0] pend_m = '0;
    logic [7:0]   prio_m [N];

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    irq_reg_bank #(.K(K), .PRIO_BITS(PB), .BYTE_WRITES(1)) i_irq_reg_bank (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .irq_req(irq_req), .irq_active(irq_active),
        .win_valid(win_valid), .win_id(win_id)
    );

    irq_reg_bank #(.K(1), .PRIO_BITS(PB), .BYTE_WRITES(0)) i_irq_reg_bank_wo (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_wo), .bus_rvalid(rvalid_wo),
        .irq_req(32'h0), .irq_active(32'h0),
        .win_valid(win_valid_wo), .win_id(win_id_wo)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        int idx;
        int w;
        logic [31:0] r;
        idx = int'(a[4:0]);
        r = '0;
        case (a[7:5])
            3'd0, 3'd1: if (idx < K) r = en_m[idx*32 +: 32];
            3'd2, 3'd3: if (idx < K) r = pend_m[idx*32 +: 32];
            3'd4:       if (idx < K) r = irq_active[idx*32 +: 32];
            3'd6, 3'd7: begin
                w = int'(a) - 'hC0;
                if (w < N/4) for (int f = 0; f < 4; f++) r[f*8 +: 8] = prio_m[w*4+f];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_write(logic [7:0] a, logic [3:0] be, logic [31:0] d);
        logic [31:0] m;
        int idx;
        int w;
        for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
        m = m & d;
        idx = int'(a[4:0]);
        case (a[7:5])
            3'd0: if (idx < K) en_m[idx*32 +: 32] = en_m[idx*32 +: 32] | m;
            3'd1: if (idx < K) en_m[idx*32 +: 32] = en_m[idx*32 +: 32] & ~m;
            3'd2: if (idx < K) pend_m[idx*32 +: 32] = pend_m[idx*32 +: 32] | m;
            3'd3: if (idx < K) pend_m[idx*32 +: 32] = pend_m[idx*32 +: 32] & ~m;
            3'd6, 3'd7: begin
                w = int'(a) - 'hC0;
                if (w < N/4) for (int f = 0; f < 4; f++)
                    if (be[f]) prio_m[w*4+f] = d[f*8 +: 8] & PMASK;
            end
            default: ;
        endcase
    endtask

    task automatic do_write(logic [7:0] a, logic [3:0] be, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, be, d);
    endtask

    task automatic do_read(logic [7:0] a, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp_rd(a));
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_win(string tag);
        logic found;
        logic [7:0] best;
        int id;
        found = 1'b0; best = 8'hFF; id = 0;
        for (int n = 0; n < N; n++)
            if (en_m[n] && pend_m[n] && (!found || prio_m[n] < best)) begin
                found = 1'b1; best = prio_m[n]; id = n;
            end
        chk({tag, " valid"}, 32'(win_valid), 32'(found));
        if (found) chk({tag, " id"}, 32'(win_id), 32'(id));
    endtask

    // Monitor: pops expected read data as responses appear.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 unexpected response act=%h exp=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int n = 0; n < N; n++) prio_m[n] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state
        chk("R10 reset win_valid", 32'(win_valid), 32'h0);
        do_read(8'h00, "R3 reset enable w0");
        do_read(8'h41, "R3 reset pending w1");
        do_read(8'hC0, "R7 reset prio w0");

        // R2 enable set/clear, R1 word mapping (line 40 = word 1 bit 8)
        do_write(8'h00, 4'hF, 32'h8000_0011);
        do_write(8'h01, 4'hF, 32'h0000_0100);
        do_read(8'h00, "R2 set-enable w0");
        do_read(8'h20, "R3 clear-enable group reads enable w0");
        do_read(8'h21, "R1 line 40 in word 1");
        do_write(8'h20, 4'hF, 32'h0000_0001);
        do_write(8'h00, 4'hF, 32'h0000_0000);
        do_read(8'h00, "R2 clear and zero write");

        // R1 byte lanes
        do_write(8'h00, 4'b0010, 32'hFFFF_FFFF);
        do_read(8'h00, "R1 lane 1 set only");
        do_write(8'h20, 4'b0010, 32'hFFFF_FFFF);
        do_read(8'h20, "R1 lane 1 clear only");

        // R4 pending
        do_write(8'h40, 4'hF, 32'h0000_0030);
        do_read(8'h60, "R4 set-pending read via clear group");
        do_write(8'h60, 4'hF, 32'h0000_0020);
        do_read(8'h40, "R4 clear-pending");
        chk_win("R10 single line 4");

        // R7/R10 priorities and ties
        do_write(8'hC1, 4'b0001, 32'h0000_00FF);
        do_read(8'hC1, "R7 line 4 truncated");
        do_write(8'h40, 4'hF, 32'h8000_0000);
        chk_win("R10 lower value wins line 31");
        do_write(8'hC7, 4'hF, 32'h5A5A_5A5A);
        do_read(8'hC7, "R7 word write packs four fields");
        do_write(8'h41, 4'hF, 32'h0000_0100);
        do_write(8'hCA, 4'b0001, 32'h0000_0041);
        chk_win("R10 tie goes to lower index");
        do_write(8'hCA, 4'b0001, 32'h0000_0020);
        chk_win("R10 line 40 more urgent");
        do_read(8'hCA, "R8 byte write line 40");

        // R5 active group
        irq_active = 64'h0000_0003_F000_000F;
        do_read(8'h80, "R5 active w0");
        do_write(8'h80, 4'hF, 32'hFFFF_FFFF);
        do_read(8'h80, "R5 write ignored w0");
        do_read(8'h81, "R5 active w1");

        // R6 reserved and unmapped
        do_write(8'h02, 4'hF, 32'hFFFF_FFFF);
        do_read(8'h02, "R6 reserved enable word");
        do_read(8'h00, "R6 reserved write left enables");
        do_write(8'hA0, 4'hF, 32'hFFFF_FFFF);
        do_read(8'hA0, "R6 unmapped");
        do_read(8'hD0, "R6 priority beyond lines");

        // R9 request edges
        @(negedge clk); irq_req[7] = 1'b1;
        @(negedge clk); pend_m[7] = 1'b1;
        do_read(8'h40, "R9 edge sets pending");
        do_write(8'h60, 4'hF, 32'h0000_0080);
        do_read(8'h40, "R9 held level does not re-pend");
        @(negedge clk); irq_req[7] = 1'b0;
        @(negedge clk);
        irq_req[7] = 1'b1;
        bus_wr = 1'b1; bus_addr = 8'h60; bus_be = 4'hF; bus_wdata = 32'h0000_0080;
        @(negedge clk);
        bus_wr = 1'b0;
        pend_m[7] = 1'b1;
        do_read(8'h40, "R9 edge beats clear");

        // R11 read and write in the same cycle returns old state
        @(negedge clk);
        bus_rd = 1'b1; bus_wr = 1'b1; bus_addr = 8'h01; bus_be = 4'hF; bus_wdata = 32'h0000_F000;
        exp_q.push_back(exp_rd(8'h01));
        tag_q.push_back("R11 read before same-cycle write");
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0;
        model_write(8'h01, 4'hF, 32'h0000_F000);
        do_read(8'h01, "R11 write landed");

        // R10 nothing eligible
        do_write(8'h20, 4'hF, 32'hFFFF_FFFF);
        do_write(8'h21, 4'hF, 32'hFFFF_FFFF);
        chk_win("R10 none eligible");

        // R8 word-only variant
        do_write(8'hC2, 4'b0001, 32'h0000_00FF);
        do_read(8'hC2, "R8 byte mode partial write");
        chk("R8 word-only ignores partial write", rdata_wo, 32'h0);
        do_write(8'hC2, 4'hF, 32'h8080_8080);
        do_read(8'hC2, "R8 byte mode full write");
        chk("R8 word-only full write", rdata_wo, 32'h8080_8080);

        repeat (3) @(negedge clk);
        chk("R11 all responses seen", 32'(exp_q.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule